// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a serial-bus slave that gives an external controller byte-wide access to a small register file. Each transfer opens when chip select falls. The first sixteen bits shifted in form a command word. Its top bit picks the direction and its remaining fifteen bits name a starting register. Whole data bytes follow, and each one moves between the bus and the register file. A transfer may carry any number of bytes. The register address steps down by one after every byte, and the stream stops when chip select rises.

The slave works in two pin arrangements. In four-wire mode, read data comes out on a dedicated output and the data pin only receives. In three-wire mode, read data is sent back on the shared data pin. The slave turns that pin around itself: it starts driving only after the command word is complete, and it lets go when chip select rises. Input bits are taken on the rising serial-clock edge. Output bits change on the falling edge, so the controller can capture each one on the following rising edge.

Top module: `spi_rs_slave`

## Requirements
- R1: The first 16 rising SCLK edges after CSB falls shift in a command word, MSB first. Bit 15 is the direction, where 0 means write and 1 means read. Bits 14..0 are the starting register address.
- R2: In a write, every group of 8 rising edges after the command word forms one data byte, MSB first. The byte is stored at the current address on the eighth rising edge of that byte.
- R3: After each complete data byte the current address decreases by one. Address 0 wraps to 0x7FFF.
- R4: In a read, the addressed register's MSB is presented after the falling edge that follows the 16th rising edge. The remaining bits follow on successive falling edges, MSB first. Each later byte comes from the next lower address.
- R5: With `three_wire` = 0, read data appears on `sdo` and `sdio_oe` stays 0.
- R6: With `three_wire` = 1, read data appears on `sdio_out` with `sdio_oe` = 1, and `sdo` stays 0. `sdio_oe` is never 1 before the 16th rising edge of a transfer.
- R7: While CSB is high, `sdo` and `sdio_oe` are 0. A data byte that is cut short by CSB rising is not stored.
- R8: Registers exist only at addresses 0 to DEPTH-1 (default 16). A write to any other address changes nothing, and a read from it returns 0x00.
- R9: `rst_n` low clears every register to 0x00. Register 0x009 is a scratch register that reads back whatever was last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| csb | input | 1 | Chip select, active low; when high it aborts the transfer |
| sclk | input | 1 | Serial clock |
| three_wire | input | 1 | 1: read data on the shared pin; 0: read data on sdo |
| sdio_in | input | 1 | Input half of the shared data pin |
| sdio_out | output | 1 | Output half of the shared data pin |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo | output | 1 | Dedicated read-data output (four-wire mode) |
| wr_stb | output | 1 | High during the last bit of a write byte |
| wr_addr | output | 15 | Address of the byte being written |
| wr_data | output | 8 | Value of the byte being written |

## Verification
A table of single-byte write-then-read pairs covers alternating bit patterns, single-bit values, both pin modes, both edges of the register range and addresses outside it. Alternating patterns expose bit-order and off-by-one shift errors. The out-of-range rows show whether address decoding is complete. Directed streams then separate correct downward address stepping from a frozen or rising address: a four-byte write followed by single reads, and multi-byte reads in both pin modes. Chip select is raised partway through a byte to show that partial bytes are dropped. A stream that starts at address 0 confirms the wrap. Throughout every transfer the bench watches the pin enables to catch early or wrong-pin driving.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } spi_dir_e;
endpackage

// File: rtl/spi_rs_seq.sv
// Bit sequencer: command phase counter, then byte position counter.
module spi_rs_seq #(
  parameter int INSTR_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic sclk,
  input  logic csb,
  output logic in_instr,
  output logic instr_last,
  output logic in_data,
  output logic byte_last
);
  localparam int CW = $clog2(INSTR_W + 1);
  localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bc_q, bc_d;

  always_comb begin
    in_data    = (cnt_q == CW'(INSTR_W));
    in_instr   = !in_data;
    instr_last = (cnt_q == CW'(INSTR_W - 1));
    byte_last  = in_data && (bc_q == BW'(BYTE_W - 1));
    cnt_d      = in_data ? cnt_q : cnt_q + 1'b1;
    if (!in_data || byte_last) bc_d = '0;
    else                       bc_d = bc_q + 1'b1;
  end

  always_ff @(posedge sclk or posedge csb) begin
    if (csb) begin
      cnt_q <= '0;
      bc_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      bc_q  <= bc_d;
    end
  end
endmodule

// File: rtl/spi_rs_shift.sv
// Receive and transmit shifters; transmit bit launched on falling edge.
module spi_rs_shift #(
  parameter int W = 8
) (
  input  logic         sclk,
  input  logic         csb,
  input  logic         in_data,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         sdi,
  input  logic         drive_req,
  output logic [W-1:0] rx_word,
  output logic         launch_bit,
  output logic         drive
);
  logic [W-1:0] rx_q, rx_d, tx_q, tx_d;

  always_comb begin
    rx_word = {rx_q[W-2:0], sdi};
    rx_d    = in_data ? rx_word : rx_q;
    if (load)         tx_d = load_val;
    else if (in_data) tx_d = {tx_q[W-2:0], 1'b0};
    else              tx_d = tx_q;
  end

  always_ff @(posedge sclk or posedge csb) begin
    if (csb) begin
      rx_q <= '0;
      tx_q <= '0;
    end else begin
      rx_q <= rx_d;
      tx_q <= tx_d;
    end
  end

  always_ff @(negedge sclk or posedge csb) begin
    if (csb) begin
      launch_bit <= 1'b0;
      drive      <= 1'b0;
    end else begin
      launch_bit <= tx_q[W-1];
      drive      <= drive_req;
    end
  end
endmodule

// File: rtl/spi_rs_regfile.sv
// Byte register file; unmapped addresses ignore writes and read as zero.
module spi_rs_regfile #(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 16,
  parameter int W      = 8
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)                                 mem[g] <= '0;
      else if (we && (waddr == ADDR_W'(g)))       mem[g] <= wdata;
    end
  end

  always_comb begin
    if (raddr < ADDR_W'(DEPTH)) rdata = mem[raddr[IDX_W-1:0]];
    else                        rdata = '0;
  end
endmodule

// File: rtl/spi_rs_slave.sv
module spi_rs_slave
  import spi_rs_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              rst_n,
  input  logic              csb,
  input  logic              sclk,
  input  logic              three_wire,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int INSTR_W = ADDR_W + 1;

  logic in_instr, instr_last, in_data, byte_last;
  logic [ADDR_W-1:0] cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  spi_dir_e          dir_q, dir_d;
  logic [DATA_W-1:0] rx_word, rd_data;
  logic              launch_bit, drive, drive_req, load;

  spi_rs_seq #(.INSTR_W(INSTR_W), .BYTE_W(DATA_W)) u_seq (
    .sclk(sclk), .csb(csb), .in_instr(in_instr), .instr_last(instr_last),
    .in_data(in_data), .byte_last(byte_last)
  );

  always_comb begin
    cmd_d  = in_instr ? {cmd_q[ADDR_W-2:0], sdio_in} : cmd_q;
    dir_d  = dir_q;
    addr_d = addr_q;
    if (instr_last) begin
      dir_d  = spi_dir_e'(cmd_q[ADDR_W-1]);
      addr_d = {cmd_q[ADDR_W-2:0], sdio_in};
    end else if (byte_last) begin
      addr_d = addr_q - 1'b1;
    end
  end

  always_ff @(posedge sclk or posedge csb) begin
    if (csb) begin
      cmd_q  <= '0;
      addr_q <= '0;
      dir_q  <= DIR_WRITE;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      dir_q  <= dir_d;
    end
  end

  assign load      = instr_last || byte_last;
  assign drive_req = in_data && (dir_q == DIR_READ);
  assign wr_stb    = byte_last && (dir_q == DIR_WRITE);
  assign wr_addr   = addr_q;
  assign wr_data   = rx_word;

  spi_rs_shift #(.W(DATA_W)) u_shift (
    .sclk(sclk), .csb(csb), .in_data(in_data), .load(load), .load_val(rd_data),
    .sdi(sdio_in), .drive_req(drive_req), .rx_word(rx_word),
    .launch_bit(launch_bit), .drive(drive)
  );

  spi_rs_regfile #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .W(DATA_W)) u_rf (
    .sclk(sclk), .rst_n(rst_n), .we(wr_stb), .waddr(addr_q), .wdata(rx_word),
    .raddr(addr_d), .rdata(rd_data)
  );

  always_comb begin
    sdio_oe  = !csb && three_wire && drive;
    sdio_out = sdio_oe && launch_bit;
    sdo      = !csb && !three_wire && drive && launch_bit;
  end
endmodule

// File: rtl/spi_rs_checker.sv
module spi_rs_checker #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              rst_n,
  input logic              csb,
  input logic              sclk,
  input logic              three_wire,
  input logic              sdio_oe,
  input logic              sdo,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr
);
  localparam int INSTR_W = ADDR_W + 1;
  localparam int CW = $clog2(INSTR_W + 1);
  localparam int PW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CW-1:0]     edges_q;
  logic [PW-1:0]     dpos_q;
  logic              have_prev_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge sclk or posedge csb) begin
    if (csb) begin
      edges_q     <= '0;
      dpos_q      <= '0;
      have_prev_q <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      if (edges_q != CW'(INSTR_W)) edges_q <= edges_q + 1'b1;
      else if (dpos_q == PW'(DATA_W - 1)) dpos_q <= '0;
      else dpos_q <= dpos_q + 1'b1;
      if (wr_stb) begin
        have_prev_q <= 1'b1;
        prev_addr_q <= wr_addr;
      end
    end
  end

  assert_oe_after_cmd_R6: assert property (@(posedge sclk) disable iff (csb || !rst_n)
    sdio_oe |-> (edges_q == CW'(INSTR_W)));
  assert_sdo_quiet_3w_R6: assert property (@(posedge sclk) disable iff (csb || !rst_n)
    three_wire |-> !sdo);
  assert_no_oe_4w_R5: assert property (@(posedge sclk) disable iff (csb || !rst_n)
    !three_wire |-> !sdio_oe);
  assert_commit_on_boundary_R2: assert property (@(posedge sclk) disable iff (csb || !rst_n)
    wr_stb |-> (edges_q == CW'(INSTR_W) && dpos_q == PW'(DATA_W - 1)));
  assert_addr_descends_R3: assert property (@(posedge sclk) disable iff (csb || !rst_n)
    (wr_stb && have_prev_q) |-> (wr_addr == prev_addr_q - 1'b1));

  always_comb begin
    if (csb === 1'b1) begin
      assert_idle_outputs_R7: assert (!sdio_oe && !sdo);
    end
  end
endmodule

bind spi_rs_slave spi_rs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .rst_n(rst_n), .csb(csb), .sclk(sclk), .three_wire(three_wire),
  .sdio_oe(sdio_oe), .sdo(sdo), .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/sim_spi_rs_slave.sv
module sim_spi_rs_slave;
  logic rst_n, csb, sclk, three_wire, sdio_in;
  logic sdio_out, sdio_oe, sdo, wr_stb;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;

  spi_rs_slave u0 (
    .rst_n(rst_n), .csb(csb), .sclk(sclk), .three_wire(three_wire),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic early_oe, wrong_pin, missing_oe;

  // {three_wire, address, data}
  localparam logic [23:0] VEC [8] = '{
    {1'b0, 15'h0009, 8'h5A}, {1'b1, 15'h0009, 8'hA5},
    {1'b0, 15'h0000, 8'h81}, {1'b1, 15'h000F, 8'h3C},
    {1'b0, 15'h0010, 8'h77}, {1'b1, 15'h7FFF, 8'hFF},
    {1'b0, 15'h0004, 8'h01}, {1'b1, 15'h000A, 8'h80}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, input logic data_phase, input logic rd, output logic r);
    sdio_in = b;
    #4;
    r = three_wire ? sdio_out : sdo;
    if (!data_phase && (sdio_oe || sdo)) early_oe = 1'b1;
    if (three_wire && sdo) wrong_pin = 1'b1;
    if (!three_wire && sdio_oe) wrong_pin = 1'b1;
    if (data_phase && rd && three_wire && !sdio_oe) missing_oe = 1'b1;
    #1 sclk = 1'b1;
    #5 sclk = 1'b0;
  endtask

  task automatic txn(input logic rd, input logic [14:0] addr, input int nbytes, input int extra);
    logic [15:0] cmd;
    logic r;
    cmd = {rd, addr};
    csb = 1'b0;
    #5;
    for (int i = 15; i >= 0; i--) bit_x(cmd[i], 1'b0, rd, r);
    for (int b = 0; b < nbytes; b++)
      for (int k = 7; k >= 0; k--) begin
        bit_x(wbuf[b][k], 1'b1, rd, r);
        rbuf[b][k] = r;
      end
    for (int e = 0; e < extra; e++) bit_x(1'b1, 1'b1, rd, r);
    #2 csb = 1'b1;
    #8;
  endtask

  task automatic wr1(input logic [14:0] a, input logic [7:0] d);
    wbuf[0] = d;
    txn(1'b0, a, 1, 0);
  endtask

  task automatic rd1(input logic [14:0] a, output logic [7:0] d);
    wbuf[0] = 8'h00;
    txn(1'b1, a, 1, 0);
    d = rbuf[0];
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; csb = 1'b1; sclk = 1'b0; three_wire = 1'b0; sdio_in = 1'b0;
    early_oe = 1'b0; wrong_pin = 1'b0; missing_oe = 1'b0;
    #20 rst_n = 1'b1;
    #10;
    check("R7 idle sdo after reset", sdo, 0);
    check("R7 idle sdio_oe after reset", sdio_oe, 0);
    rd1(15'h0009, v);
    check("R9 scratch clear after reset", v, 8'h00);

    // table walk: write then read back (R1 R2 R4 R8 R9)
    foreach (VEC[i]) begin
      three_wire = VEC[i][23];
      wr1(VEC[i][22:8], VEC[i][7:0]);
      rd1(VEC[i][22:8], v);
      check($sformatf("R1/R2/R4/R8 vector %0d", i), v,
            (VEC[i][22:8] < 15'd16) ? {24'd0, VEC[i][7:0]} : 32'd0);
      check($sformatf("R7 outputs idle after vector %0d", i), {sdo, sdio_oe}, 0);
    end

    // R3: four-byte descending write from 0x00C
    three_wire = 1'b0;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    txn(1'b0, 15'h000C, 4, 0);
    rd1(15'h000C, v); check("R3 byte0 at 0x00C", v, 8'hA1);
    rd1(15'h000B, v); check("R3 byte1 at 0x00B", v, 8'hB2);
    rd1(15'h000A, v); check("R3 byte2 at 0x00A", v, 8'hC3);
    rd1(15'h0009, v); check("R3 byte3 at 0x009", v, 8'hD4);

    // R4/R5: multi-byte read, four-wire
    for (int b = 0; b < 3; b++) wbuf[b] = 8'h00;
    txn(1'b1, 15'h000B, 3, 0);
    check("R4 R5 stream read byte0", rbuf[0], 8'hB2);
    check("R4 R5 stream read byte1", rbuf[1], 8'hC3);
    check("R4 R5 stream read byte2", rbuf[2], 8'hD4);

    // R4/R6: multi-byte read, three-wire
    three_wire = 1'b1;
    txn(1'b1, 15'h000C, 3, 0);
    check("R4 R6 3-wire read byte0", rbuf[0], 8'hA1);
    check("R4 R6 3-wire read byte1", rbuf[1], 8'hB2);
    check("R4 R6 3-wire read byte2", rbuf[2], 8'hC3);
    three_wire = 1'b0;

    // R7: partial bytes discarded
    wr1(15'h0009, 8'h11);
    txn(1'b0, 15'h0009, 0, 5);
    rd1(15'h0009, v); check("R7 partial byte dropped", v, 8'h11);
    wbuf[0] = 8'h22;
    txn(1'b0, 15'h0005, 1, 3);
    rd1(15'h0005, v); check("R2 full byte kept", v, 8'h22);
    rd1(15'h0004, v); check("R7 trailing partial dropped", v, 8'h01);

    // R3/R8: wrap from 0 to 0x7FFF
    wbuf[0] = 8'h99; wbuf[1] = 8'h66;
    txn(1'b0, 15'h0000, 2, 0);
    rd1(15'h0000, v); check("R3 wrap first byte", v, 8'h99);
    rd1(15'h000F, v); check("R8 wrap write not aliased", v, 8'h3C);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    txn(1'b1, 15'h0000, 2, 0);
    check("R3 wrap read byte0", rbuf[0], 8'h99);
    check("R8 wrap read unmapped", rbuf[1], 8'h00);

    check("R6 no drive during command", early_oe, 0);
    check("R5 R6 no drive on wrong pin", wrong_pin, 0);
    check("R6 enable held through read data", missing_oe, 0);

    // R9: reset clears registers
    rst_n = 1'b0; #10 rst_n = 1'b1; #10;
    rd1(15'h0009, v); check("R9 scratch cleared by reset", v, 8'h00);
    rd1(15'h000C, v); check("R9 reg 0x00C cleared by reset", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule